// File: doc/BRIEF.md
# Special-Form Modular Multiplier

This block multiplies two residues and reduces the product modulo a prime of the form q = k·2^m + 1. It uses no general division. The full product is split at bit m. The block then forms k times the low part minus the high part. This works because k·2^m is congruent to −1 modulo such a q. The result is congruent to k·a·b rather than a·b. Callers remove the extra factor k outside the block, usually by scaling the stored twiddle factors by k⁻¹ mod q ahead of time.

Three moduli are built in: 3329, 12289 and 8380417. A 2-bit select input picks one for each operation, so lattice transforms with different parameter sets can share one datapath. A build-time option sets the output form:

- **Canonical:** a residue in [0, q).
- **Signed:** the raw k·low − high value.

The pipeline has three stages: multiply, split-and-combine, then correction. It accepts one operation per cycle.

Top module: `kred_mul`

## Requirements
- R1: `set_i` selects the modulus. Code 0 gives q=3329 (k=13, m=8). Code 1 gives q=12289 (k=3, m=12). Code 2 gives q=8380417 (k=1023, m=13). Code 3 is reserved and behaves exactly like code 0.
- R2: With CANON=1 and operands a, b < q, `res_o` equals (k·a·b) mod q, zero-extended. Its value lies in [0, q).
- R3: With CANON=0, `res_o` equals k·(C mod 2^m) − (C >> m) for C = a·b, in 40-bit two's complement.
- R4: `valid_o` equals `valid_i` delayed by exactly 3 clock cycles. The result for an operation appears in the same cycle as its `valid_o`.
- R5: Inputs presented while `valid_i` is low have no effect. While `valid_o` is low, `res_o` keeps the last valid result.
- R6: While `rst_ni` is low, `valid_o` and `res_o` are 0. This takes effect at once, without waiting for a clock edge.
- R7: A new operation is accepted every cycle. Each operation keeps its own modulus select through the pipeline, so consecutive operations may use different moduli.
- R8: Operand boundary values (0, 1 and q−1, including the largest product (q−1)²) give correct results for every modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation valid |
| set_i | input | 2 | Modulus select code |
| a_i | input | 23 | Operand a, must be below q |
| b_i | input | 23 | Operand b, must be below q |
| valid_o | output | 1 | Result valid |
| res_o | output | 40 | Canonical residue (CANON=1) or signed k·low − high (CANON=0) |

## Verification
The hardest case to reach is the deepest negative intermediate value for the largest modulus. There, the high part of the product is about a thousand multiples of q, and the correction stage must still land in range after a single quotient estimate. Random operand pairs seldom come near that corner. The stimulus therefore drives (q−1)·(q−1) and the other extreme pairs for each modulus directly, and adds dense sweeps of one operand against fixed extreme values of the other. Moduli are also switched on every cycle with idle gaps mixed in, to show that each operation carries its own select and that idle inputs leave the output untouched.

// File: rtl/kred_pkg.sv
package kred_pkg;
  localparam int unsigned SET_W = 2;
  localparam int unsigned K_W   = 10;
  localparam int unsigned M_W   = 4;
  localparam int unsigned Q_W   = 23;
  localparam int unsigned SH_W  = 4;
  localparam int unsigned MU_SH = 36;
  localparam int unsigned MU_W  = 32;
  localparam int unsigned M_MIN = 8;

  typedef enum logic [SET_W-1:0] {
    SET_Q3329    = 2'd0,
    SET_Q12289   = 2'd1,
    SET_Q8380417 = 2'd2,
    SET_RSVD     = 2'd3
  } kred_set_e;

  typedef struct packed {
    logic [K_W-1:0]  k;
    logic [M_W-1:0]  m;
    logic [Q_W-1:0]  q;
    logic [SH_W-1:0] off_sh;  // q<<off_sh bounds the largest high part
    logic [MU_W-1:0] mu;      // floor(2^MU_SH / q)
  } kred_cfg_t;

  function automatic logic [MU_W-1:0] calc_mu(input longint unsigned q);
    longint unsigned one_sh;
    one_sh = 64'd1 << MU_SH;
    return MU_W'(one_sh / q);
  endfunction

  localparam logic [MU_W-1:0] MU_3329    = calc_mu(64'd3329);
  localparam logic [MU_W-1:0] MU_12289   = calc_mu(64'd12289);
  localparam logic [MU_W-1:0] MU_8380417 = calc_mu(64'd8380417);

  function automatic kred_cfg_t cfg_of(input logic [SET_W-1:0] sel);
    kred_cfg_t c;
    case (kred_set_e'(sel))
      SET_Q12289: begin
        c.k = K_W'(3);    c.m = M_W'(12); c.q = Q_W'(12289);
        c.off_sh = SH_W'(2);  c.mu = MU_12289;
      end
      SET_Q8380417: begin
        c.k = K_W'(1023); c.m = M_W'(13); c.q = Q_W'(8380417);
        c.off_sh = SH_W'(10); c.mu = MU_8380417;
      end
      default: begin  // code 0 and reserved code 3
        c.k = K_W'(13);   c.m = M_W'(8);  c.q = Q_W'(3329);
        c.off_sh = SH_W'(4);  c.mu = MU_3329;
      end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/kred_param_rom.sv
module kred_param_rom
  import kred_pkg::*;
(
  input  logic [SET_W-1:0] set_i,
  output kred_cfg_t        cfg_o
);
  always_comb cfg_o = cfg_of(set_i);
endmodule

// File: rtl/kred_fold.sv
module kred_fold
  import kred_pkg::*;
#(
  parameter int unsigned PROD_W = 46,
  parameter int unsigned RES_W  = 40
) (
  input  logic [PROD_W-1:0]       prod_i,
  input  logic [K_W-1:0]          k_i,
  input  logic [M_W-1:0]          m_i,
  output logic signed [RES_W-1:0] r_o
);
  logic [PROD_W-1:0] mask, lo, hi;
  logic [RES_W-1:0]  k_lo, hi_r;

  always_comb begin
    mask = (PROD_W'(1) << m_i) - PROD_W'(1);
    lo   = prod_i & mask;
    hi   = prod_i >> m_i;
    k_lo = RES_W'(k_i) * RES_W'(lo);
    hi_r = RES_W'(hi);
    r_o  = $signed(k_lo) - $signed(hi_r);
  end
endmodule

// File: rtl/kred_canon.sv
module kred_canon
  import kred_pkg::*;
#(
  parameter int unsigned RES_W = 40
) (
  input  logic signed [RES_W-1:0] r_i,
  input  logic [Q_W-1:0]          q_i,
  input  logic [MU_W-1:0]         mu_i,
  input  logic [SH_W-1:0]         off_sh_i,
  output logic [Q_W-1:0]          c_o
);
  localparam int unsigned T_W  = RES_W + 2;
  localparam int unsigned TM_W = T_W + MU_W;

  logic [T_W-1:0]  off, t, est, rem;
  logic [TM_W-1:0] t_mu;

  always_comb begin
    // shift the signed value into a non-negative window by a multiple of q
    off  = T_W'(q_i) << off_sh_i;
    t    = T_W'($signed({{2{r_i[RES_W-1]}}, r_i}) + $signed(off));
    t_mu = TM_W'(t) * TM_W'(mu_i);
    est  = T_W'(t_mu >> MU_SH);            // quotient, at most one short
    rem  = t - T_W'(est * T_W'(q_i));
    if (rem >= T_W'(q_i)) rem = rem - T_W'(q_i);
    c_o  = Q_W'(rem);
  end
endmodule

// File: rtl/kred_mul.sv
module kred_mul
  import kred_pkg::*;
#(
  parameter int unsigned DATA_W = 23,
  parameter bit          CANON  = 1'b1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic [1:0]                        set_i,
  input  logic [DATA_W-1:0]                 a_i,
  input  logic [DATA_W-1:0]                 b_i,
  output logic                              valid_o,
  output logic [2*DATA_W-M_MIN+1:0]         res_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned RES_W  = PROD_W - M_MIN + 2;

  // stage 1: full product
  logic              v1;
  logic [SET_W-1:0]  set1;
  logic [PROD_W-1:0] prod1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; set1 <= '0; prod1 <= '0;
    end else begin
      v1 <= valid_i;
      if (valid_i) begin
        set1  <= set_i;
        prod1 <= PROD_W'(a_i) * PROD_W'(b_i);
      end
    end
  end

  // stage 2: split at bit m and combine
  kred_cfg_t               cfg2;
  logic signed [RES_W-1:0] r_nxt;
  logic                    v2;
  logic [SET_W-1:0]        set2;
  logic signed [RES_W-1:0] r2;

  kred_param_rom u_rom_s2 (.set_i(set1), .cfg_o(cfg2));

  kred_fold #(.PROD_W(PROD_W), .RES_W(RES_W)) u_fold (
    .prod_i(prod1), .k_i(cfg2.k), .m_i(cfg2.m), .r_o(r_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; set2 <= '0; r2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        set2 <= set1;
        r2   <= r_nxt;
      end
    end
  end

  // stage 3: optional correction into [0, q)
  logic [RES_W-1:0] res_nxt;

  if (CANON) begin : g_canon
    kred_cfg_t      cfg3;
    logic [Q_W-1:0] c3;
    kred_param_rom u_rom_s3 (.set_i(set2), .cfg_o(cfg3));
    kred_canon #(.RES_W(RES_W)) u_canon (
      .r_i(r2), .q_i(cfg3.q), .mu_i(cfg3.mu), .off_sh_i(cfg3.off_sh), .c_o(c3)
    );
    assign res_nxt = RES_W'(c3);
  end else begin : g_signed
    logic [SET_W-1:0] unused_set;
    assign unused_set = set2;
    assign res_nxt    = r2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; res_o <= '0;
    end else begin
      valid_o <= v2;
      if (v2) res_o <= res_nxt;
    end
  end
endmodule

// File: rtl/kred_mul_chk.sv
module kred_mul_chk
  import kred_pkg::*;
#(
  parameter int unsigned DATA_W = 23,
  parameter bit          CANON  = 1'b1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [1:0]                set_i,
  input logic                      valid_o,
  input logic [2*DATA_W-M_MIN+1:0] res_o
);
  localparam int unsigned RES_W = 2 * DATA_W - M_MIN + 2;

  logic [1:0]       cnt;
  logic [SET_W-1:0] sp1, sp2, sp3;
  logic             vp1, vp2, vp3;
  kred_cfg_t        cfg3;
  logic [RES_W-1:0] q3, hi_bnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; sp1 <= '0; sp2 <= '0; sp3 <= '0;
      vp1 <= 1'b0; vp2 <= 1'b0; vp3 <= 1'b0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      sp1 <= set_i; sp2 <= sp1; sp3 <= sp2;
      vp1 <= valid_i; vp2 <= vp1; vp3 <= vp2;
    end
  end

  always_comb begin
    cfg3   = cfg_of(sp3);
    q3     = RES_W'(cfg3.q);
    hi_bnd = RES_W'(cfg3.k) * ((RES_W'(1) << cfg3.m) - RES_W'(1));
  end

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3) |-> (valid_o == vp3));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && !valid_o) |-> $stable(res_o));

  // R6
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));

  if (CANON) begin : g_canon_chk
    // R2
    canon_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == 2'd3 && valid_o) |-> (res_o < q3));
  end else begin : g_signed_chk
    // R3
    signed_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == 2'd3 && valid_o) |-> ($signed(res_o) <= $signed(hi_bnd)));
  end
endmodule

bind kred_mul kred_mul_chk #(.DATA_W(DATA_W), .CANON(CANON)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .set_i(set_i),
  .valid_o(valid_o), .res_o(res_o)
);

// File: tb/kred_mul_bench.sv
module kred_mul_bench;
  localparam int DW = 23;
  localparam int RW = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] set_i = '0;
  logic [DW-1:0] a_i = '0, b_i = '0;
  logic vo_c, vo_r;
  logic [RW-1:0] res_c, res_r;

  always #5 clk_i = ~clk_i;

  kred_mul #(.DATA_W(DW), .CANON(1'b1)) u_kred_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .set_i(set_i),
    .a_i(a_i), .b_i(b_i), .valid_o(vo_c), .res_o(res_c));

  kred_mul #(.DATA_W(DW), .CANON(1'b0)) u_kred_mul_raw (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .set_i(set_i),
    .a_i(a_i), .b_i(b_i), .valid_o(vo_r), .res_o(res_r));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit hv[3];
  longint hc[3], hr[3];
  string ht[3];
  longint last_c = 0, last_r = 0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void pset(input logic [1:0] s, output longint k,
                               output longint m, output longint q);
    case (s)
      2'd1: begin k = 3;    m = 12; q = 12289;   end
      2'd2: begin k = 1023; m = 13; q = 8380417; end
      default: begin k = 13; m = 8; q = 3329; end
    endcase
  endfunction

  function automatic longint qof(input logic [1:0] s);
    longint k, m, q;
    pset(s, k, m, q);
    return q;
  endfunction

  function automatic longint rnd(input longint lim);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return longint'(rng) % lim;
  endfunction

  function automatic longint sx(input logic [RW-1:0] v);
    return {{(64-RW){v[RW-1]}}, v};
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hc[i] = 0; hr[i] = 0; ht[i] = ""; end
    last_c = 0; last_r = 0;
  endtask

  task automatic step(input bit v, input logic [1:0] s, input longint a,
                      input longint b, input string tag);
    longint k, m, q, c, lo, hi;
    @(negedge clk_i);
    chk("R4 valid canon", longint'(vo_c), longint'(hv[2]));
    chk("R4 valid raw", longint'(vo_r), longint'(hv[2]));
    if (hv[2]) begin
      chk(ht[2], longint'(res_c), hc[2]);
      chk("R3 signed fold", sx(res_r), hr[2]);
      last_c = hc[2]; last_r = hr[2];
    end else begin
      chk("R5 hold canon", longint'(res_c), last_c);
      chk("R5 hold raw", sx(res_r), last_r);
    end
    hv[2] = hv[1]; hc[2] = hc[1]; hr[2] = hr[1]; ht[2] = ht[1];
    hv[1] = hv[0]; hc[1] = hc[0]; hr[1] = hr[0]; ht[1] = ht[0];
    pset(s, k, m, q);
    c  = a * b;
    lo = c & ((64'sd1 <<< m) - 1);
    hi = c >>> m;
    hv[0] = v;
    hc[0] = ((k * a) % q) * b % q;
    hr[0] = k * lo - hi;
    ht[0] = tag;
    valid_i = v; set_i = s; a_i = DW'(a); b_i = DW'(b);
  endtask

  task automatic op(input logic [1:0] s, input longint a, input longint b, input string tag);
    longint q;
    q = qof(s);
    if (a == 0 || b == 0 || a == q - 1 || b == q - 1) step(1'b1, s, a, b, "R8 boundary");
    else step(1'b1, s, a, b, tag);
  endtask

  task automatic idle();
    step(1'b0, 2'(rnd(4)), rnd(1 << DW), rnd(1 << DW), "R5");
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic longint corner(input longint i, input longint q, input longint a);
    case (i % 5)
      0: return 0;
      1: return 1;
      2: return q - 1;
      3: return q / 2;
      default: return (a * 7 + 11) % q;
    endcase
  endfunction

  initial begin
    clear_hist();
    repeat (3) @(negedge clk_i);
    // R6 reset state
    chk("R6 reset valid", longint'(vo_c | vo_r), 0);
    chk("R6 reset res canon", longint'(res_c), 0);
    chk("R6 reset res raw", longint'(res_r), 0);
    rst_ni = 1'b1;

    // R2 sweep for set 0
    for (longint a = 0; a < 3329; a++) begin
      op(2'd0, a, corner(a, 3329, a), "R2 set0");
      if (a % 9 == 8) idle();
    end
    // R2 sweep for set 1
    for (longint a = 0; a < 12289; a++) begin
      op(2'd1, a, corner(a, 12289, a), "R2 set1");
      if (a % 11 == 10) idle();
    end
    // R8 extremes on every modulus
    for (int s = 0; s < 4; s++) begin
      longint q;
      q = qof(2'(s));
      op(2'(s), q - 1, q - 1, "R8");
      op(2'(s), q - 1, 1, "R8");
      op(2'(s), 1, q - 1, "R8");
      op(2'(s), 0, 0, "R8");
    end
    // R2 random for set 2
    for (int i = 0; i < 15000; i++) begin
      op(2'd2, rnd(8380417), rnd(8380417), "R2 set2");
      if (i % 13 == 12) idle();
    end
    // R1 reserved code mirrors code 0
    for (int i = 0; i < 1500; i++) op(2'd3, rnd(3329), rnd(3329), "R1 reserved");
    // R7 modulus changes every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      s = 2'(rnd(4));
      op(s, rnd(qof(s)), rnd(qof(s)), "R7 mixed");
      if (i % 17 == 16) idle();
    end
    flush();

    // R6 asynchronous reset with operations in flight
    op(2'd2, 8380416, 8380416, "R7");
    op(2'd1, 5, 7, "R7");
    op(2'd0, 100, 200, "R7");
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0;
    #1;
    chk("R6 async valid", longint'(vo_c | vo_r), 0);
    chk("R6 async res canon", longint'(res_c), 0);
    chk("R6 async res raw", longint'(res_r), 0);
    clear_hist();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 50; i++) op(2'(i % 3), rnd(3329), rnd(3329), "R2 after reset");
    flush();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(64'd10 * 64'd200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule